// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Receive FIFO

This block receives 8-bit words over a clocked serial link. A serial clock and a serial data line come from outside. Both are brought into the system clock domain, and the data line is sampled on every rising edge of the synchronized serial clock. Bits arrive least-significant first. When the eighth bit of a word has arrived, the word is moved from the shift register into a 16-entry receive FIFO, as long as the FIFO has room.

A full FIFO at the moment a word completes is an overrun. The word is dropped and an overrun flag is set. From then on the receiver ignores the line until the host clears that flag, and the next word after the clear starts again at bit 0.

A data-ready flag is set when the FIFO fill count reaches a programmable trigger level. The block has two interrupt requests: one for data-ready and one for overrun. Each is gated by enable bits. The host reaches everything through a small register port. Register map (2-bit address):
- Address 0: reading returns the oldest FIFO entry and pops it.
- Address 1: control register.
- Address 2: flag register.
- Address 3: reading returns the FIFO count.

Top module: `sync_serial_rx`

## Requirements
- R1: The first bit sampled in a word ends up in bit 0 of the stored byte, and the eighth bit ends up in bit 7.
- R2: After 8 sampled rising edges of the serial clock, the word is appended to the FIFO and the count at address 3 goes up by one. Reads at address 0 return the words in arrival order, and the count never exceeds 16.
- R3: Control bits 7:4 hold the trigger level minus one, so the level runs from 1 to 16. The data-ready flag (flag register bit 0) becomes 1 once the count is at or above the level.
- R4: Writing a 0 to flag register bit 0 clears the data-ready flag only while the count is below the trigger level. While the count is at or above the level, that write has no effect.
- R5: A word that completes while the FIFO holds 16 entries is discarded, and the overrun flag (flag register bit 1) is set. The count stays 16.
- R6: While the overrun flag is 1, serial clock edges shift nothing in. The flag is cleared by writing a 0 to flag register bit 1, and the next word after the clear starts at bit 0.
- R7: `irqRxFull` is high exactly while the data-ready flag is 1 and the receive interrupt enable (control bit 1) is 1.
- R8: `irqOverrun` is high exactly while the overrun flag is 1 and either control bit 1 or the error interrupt enable (control bit 2) is 1.
- R9: Control bit 0 is the receive enable. While it is 0, serial edges are ignored and the bit counter returns to 0, so a word cut short by disabling the receiver is lost.
- R10: After reset, the flags, the count, the control register and both interrupt requests are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serClk | input | 1 | Serial clock, asynchronous to clk |
| serData | input | 1 | Serial data, sampled on serial clock rising edges |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops the FIFO at address 0) |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr |
| irqRxFull | output | 1 | Data-ready interrupt request |
| irqOverrun | output | 1 | Overrun interrupt request |

## Verification
The bench drives words chosen to expose bit-order errors. A lone 0x01 and a lone 0x80 separate LSB-first from MSB-first assembly. A run of 16 distinct values checks FIFO ordering and the full boundary. A trigger level of 3 is tried with 2 and then 3 words stored, which shows whether the flag follows the level and whether a clear request is refused at or above it. Stray bits are sent both while the receiver is disabled and during an overrun, followed by a complete word. The data read back then shows whether the bit counter truly restarted, or whether the stray bits leaked into the next word.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    ADDR_DATA  = 2'd0,
    ADDR_CTRL  = 2'd1,
    ADDR_FLAGS = 2'd2,
    ADDR_COUNT = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic shift;    // sample one bit into the shift register
    logic dataBit;  // synchronized serial data value
    logic push;     // move completed word into FIFO
    logic pop;      // remove oldest FIFO entry
  } rx_strobe_t;
endpackage

// File: rtl/srx_datapath.sv
module srx_datapath #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  srx_pkg::rx_strobe_t  strb,
  output logic [DATA_W-1:0]    fifoHead,
  output logic [CNT_W-1:0]     fifoCount,
  output logic [DATA_W-1:0]    shiftWord
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] nextWord;

  assign nextWord = {strb.dataBit, shiftWord[DATA_W-1:1]};
  assign fifoHead = mem[rdPtr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftWord <= '0;
    else if (strb.shift) shiftWord <= nextWord;
  end

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= nextWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (strb.push) wrPtr <= bump(wrPtr);
      if (strb.pop)  rdPtr <= bump(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   fifoCount <= fifoCount + 1'b1;
        2'b01:   fifoCount <= fifoCount - 1'b1;
        default: fifoCount <= fifoCount;
      endcase
    end
  end
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serClk,
  input  logic                 serData,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [1:0]           regAddr,
  input  logic [7:0]           regWrData,
  output logic [7:0]           regRdData,
  input  logic [DATA_W-1:0]    fifoHead,
  input  logic [CNT_W-1:0]     fifoCount,
  output srx_pkg::rx_strobe_t  strb,
  output logic                 rdfFlag,
  output logic                 ovrFlag,
  output logic [CNT_W-1:0]     trigLevel,
  output logic                 rxIe,
  output logic                 errIe,
  output logic                 irqRxFull,
  output logic                 irqOverrun
);
  import srx_pkg::*;

  logic [2:0]       clkSync;
  logic [1:0]       dataSync;
  logic [7:0]       ctrlReg;
  logic [BIT_W-1:0] bitCnt;
  logic             rxOn, clkRise, frameEnd, fifoFull, setOvr;
  logic             wrFlags, clrRdf, clrOvr;

  assign rxOn      = ctrlReg[0];
  assign rxIe      = ctrlReg[1];
  assign errIe     = ctrlReg[2];
  assign trigLevel = CNT_W'(ctrlReg[7:4]) + 1'b1;

  assign clkRise  = clkSync[1] & ~clkSync[2];
  assign fifoFull = (fifoCount == CNT_W'(DEPTH));
  assign frameEnd = strb.shift && (bitCnt == BIT_W'(DATA_W - 1));
  assign setOvr   = frameEnd && fifoFull;

  assign wrFlags = regWrEn && (regAddr == ADDR_FLAGS);
  assign clrRdf  = wrFlags && !regWrData[0];
  assign clrOvr  = wrFlags && !regWrData[1];

  always_comb begin
    strb.shift   = clkRise && rxOn && !ovrFlag;
    strb.dataBit = dataSync[1];
    strb.push    = frameEnd && !fifoFull;
    strb.pop     = regRdEn && (regAddr == ADDR_DATA) && (fifoCount != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= '0;
      dataSync <= '0;
    end else begin
      clkSync  <= {clkSync[1:0], serClk};
      dataSync <= {dataSync[0], serData};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                bitCnt <= '0;
    else if (!rxOn || ovrFlag) bitCnt <= '0;
    else if (strb.shift)      bitCnt <= (frameEnd) ? '0 : bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      rdfFlag <= 1'b0;
      ovrFlag <= 1'b0;
    end else begin
      if (regWrEn && (regAddr == ADDR_CTRL)) ctrlReg <= regWrData;
      if (fifoCount >= trigLevel) rdfFlag <= 1'b1;
      else if (clrRdf)            rdfFlag <= 1'b0;
      if (setOvr)      ovrFlag <= 1'b1;
      else if (clrOvr) ovrFlag <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_DATA:  regRdData = 8'(fifoHead);
      ADDR_CTRL:  regRdData = ctrlReg;
      ADDR_FLAGS: regRdData = {6'd0, ovrFlag, rdfFlag};
      default:    regRdData = 8'(fifoCount);
    endcase
  end

  assign irqRxFull  = rdfFlag && rxIe;
  assign irqOverrun = ovrFlag && (rxIe || errIe);
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serData,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       irqRxFull,
  output logic       irqOverrun
);
  srx_pkg::rx_strobe_t strb;
  logic [DATA_W-1:0]   fifoHead, shiftWord;
  logic [CNT_W-1:0]    fifoCount, trigLevel;
  logic                rdfFlag, ovrFlag, rxIe, errIe;

  srx_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .fifoHead(fifoHead), .fifoCount(fifoCount), .strb(strb),
    .rdfFlag(rdfFlag), .ovrFlag(ovrFlag), .trigLevel(trigLevel),
    .rxIe(rxIe), .errIe(errIe),
    .irqRxFull(irqRxFull), .irqOverrun(irqOverrun)
  );

  srx_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .fifoHead(fifoHead), .fifoCount(fifoCount), .shiftWord(shiftWord)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic                clk,
  input logic                rstN,
  input srx_pkg::rx_strobe_t strb,
  input logic [CNT_W-1:0]    fifoCount,
  input logic [CNT_W-1:0]    trigLevel,
  input logic [DATA_W-1:0]   shiftWord,
  input logic                rdfFlag,
  input logic                ovrFlag,
  input logic                rxIe,
  input logic                irqRxFull,
  input logic                irqOverrun
);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));

  assert_no_push_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> fifoCount < CNT_W'(DEPTH));

  assert_ovr_when_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $past(fifoCount) == CNT_W'(DEPTH));

  assert_frozen_in_ovr_R6: assert property (@(posedge clk) disable iff (!rstN)
    ovrFlag |=> $stable(shiftWord));

  assert_rdf_at_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount >= trigLevel) |=> rdfFlag);

  assert_irq_rx_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqRxFull |-> (rdfFlag && rxIe));

  assert_irq_ovr_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqOverrun |-> ovrFlag);
endmodule

bind sync_serial_rx srx_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .fifoCount(fifoCount),
  .trigLevel(trigLevel), .shiftWord(shiftWord), .rdfFlag(rdfFlag),
  .ovrFlag(ovrFlag), .rxIe(rxIe), .irqRxFull(irqRxFull),
  .irqOverrun(irqOverrun)
);

// File: tb/tb_sync_serial_rx.sv
module tb_sync_serial_rx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serClk = 1'b0, serData = 1'b0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       irqRxFull, irqOverrun;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];

  always #2 clk = ~clk;

  sync_serial_rx dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares every FIFO read against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && regRdEn && regAddr == 2'd0) begin
      if (expQ.size() == 0) check(1'b0, "R2 unexpected read", regRdData, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(regRdData == e, "R1/R2 fifo data", regRdData, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    @(negedge clk);
    d = regRdData;
    tick(1);
  endtask

  task automatic popFifo();
    regRdEn = 1'b1; regAddr = 2'd0;
    tick(1);
    regRdEn = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    serData = b; serClk = 1'b0;
    tick(4);
    serClk = 1'b1;
    tick(4);
  endtask

  task automatic sendFrame(input logic [7:0] w, input bit stored);
    for (int i = 0; i < 8; i++) sendBit(w[i]);
    if (stored) expQ.push_back(w);
    tick(4);
  endtask

  initial begin
    logic [7:0] r;
    tick(5);
    rstN = 1'b1;
    tick(2);

    rdReg(2'd2, r); check(r == 8'h00, "R10 flags after reset", r, 0);
    rdReg(2'd3, r); check(r == 8'h00, "R10 count after reset", r, 0);
    rdReg(2'd1, r); check(r == 8'h00, "R10 control after reset", r, 0);
    check(!irqRxFull && !irqOverrun, "R10 irqs after reset", {irqRxFull, irqOverrun}, 0);

    // level 1, receive enabled, rx interrupt enabled
    wrReg(2'd1, 8'h03);
    sendFrame(8'h01, 1'b1);
    rdReg(2'd3, r); check(r == 8'd1, "R2 count after one word", r, 1);
    rdReg(2'd2, r); check(r[0], "R3 ready flag at level 1", r, 1);
    check(irqRxFull, "R7 irq with enable", irqRxFull, 1);
    popFifo();
    wrReg(2'd2, 8'h02);
    tick(1);
    rdReg(2'd2, r); check(r[0] == 1'b0, "R4 clear below level", r[0], 0);
    check(!irqRxFull, "R7 irq drops with flag", irqRxFull, 0);

    // level 3
    wrReg(2'd1, 8'h23);
    sendFrame(8'h80, 1'b1);
    sendFrame(8'h3C, 1'b1);
    rdReg(2'd2, r); check(r[0] == 1'b0, "R3 below level 3", r[0], 0);
    sendFrame(8'hA5, 1'b1);
    rdReg(2'd2, r); check(r[0], "R3 at level 3", r[0], 1);
    wrReg(2'd2, 8'h02);
    tick(1);
    rdReg(2'd2, r); check(r[0], "R4 clear ignored at level", r[0], 1);
    wrReg(2'd1, 8'h21);
    check(!irqRxFull, "R7 irq off when disabled", irqRxFull, 0);
    wrReg(2'd1, 8'h23);
    popFifo();
    wrReg(2'd2, 8'h02);
    tick(1);
    rdReg(2'd2, r); check(r[0] == 1'b0, "R4 clear after pop", r[0], 0);
    popFifo(); popFifo();

    // receive enable restarts the bit counter
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b1);
    wrReg(2'd1, 8'h22);
    sendBit(1'b0); sendBit(1'b1);
    rdReg(2'd3, r); check(r == 8'd0, "R9 nothing stored while disabled", r, 0);
    wrReg(2'd1, 8'h23);
    sendFrame(8'h5A, 1'b1);
    rdReg(2'd3, r); check(r == 8'd1, "R9 whole word after enable", r, 1);
    popFifo();

    // fill to 16, level 16, error interrupt enable only
    wrReg(2'd2, 8'h02);
    wrReg(2'd1, 8'hF5);
    for (int i = 0; i < 16; i++) sendFrame(8'(i * 37 + 3), 1'b1);
    rdReg(2'd3, r); check(r == 8'd16, "R2 count full", r, 16);
    rdReg(2'd2, r); check(r == 8'h01, "R3 level 16 ready, no overrun", r, 1);
    check(!irqOverrun, "R8 no overrun irq yet", irqOverrun, 0);
    sendFrame(8'hFF, 1'b0);
    rdReg(2'd3, r); check(r == 8'd16, "R5 count held", r, 16);
    rdReg(2'd2, r); check(r[1], "R5 overrun flag", r[1], 1);
    check(irqOverrun, "R8 irq via error enable", irqOverrun, 1);
    wrReg(2'd1, 8'hF1);
    check(!irqOverrun, "R8 irq off with both enables 0", irqOverrun, 0);
    wrReg(2'd1, 8'hF3);
    check(irqOverrun, "R8 irq via receive enable", irqOverrun, 1);
    for (int i = 0; i < 16; i++) popFifo();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    rdReg(2'd3, r); check(r == 8'd0, "R6 ignored during overrun", r, 0);
    wrReg(2'd2, 8'h01);
    tick(1);
    rdReg(2'd2, r); check(r[1] == 1'b0, "R6 overrun cleared", r[1], 0);
    wrReg(2'd1, 8'h03);
    sendFrame(8'hC3, 1'b1);
    rdReg(2'd3, r); check(r == 8'd1, "R6 fresh word after clear", r, 1);
    popFifo();
    tick(2);
    check(expQ.size() == 0, "R2 all expected words read", expQ.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule